// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Register

This block keeps the interrupt status of a real-time clock. Three event sources each send a one-cycle pulse: a periodic tick from a selected divider tap, an alarm match and an update-complete. Each pulse sets a sticky flag. Each flag has an enable bit, and the enabled flags are ORed into a single interrupt line. The same value appears as a summary bit in the status byte. Software reads the status byte to learn which events occurred. That read clears the three flags and so drops the interrupt.

The block also keeps a sticky supply-valid bit. A low-voltage detect pulls it to 0, and it stays at 0 until a read of the supply-status byte re-arms it. While the bit is 0 the alarm flag is forced to 0, because the stored time cannot be trusted. The periodic and update flags are cleared by a software RTC reset and are held clear while the RTC is disabled.

Top module: `rtc_irq_status`

## Requirements
- R1: The status byte `flag_rdata` has the summary interrupt bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3:0 always read 0.
- R2: A pulse on `periodic_tick`, `alarm_hit` or `update_done` sets its flag in the next cycle, whatever the value of the enables.
- R3: Bit 7 of `flag_rdata` and `irq_out` both equal (en_update & update) | (en_alarm & alarm) | (en_periodic & periodic), with no cycle of delay from the enables.
- R4: In a cycle with `flag_rd` high, `flag_rdata` shows the flags as they were before the read. In the next cycle all three flags are 0 and `irq_out` is low, unless R5 applies.
- R5: An event pulse that arrives in the same cycle as `flag_rd` is kept, and its flag reads 1 in the next cycle.
- R6: A high `soft_rst`, or a high `rtc_disable`, clears the periodic and update flags in the next cycle and takes priority over their event pulses. Neither input changes the alarm flag.
- R7: While the supply-valid bit is 0, the alarm flag reads 0, even when `alarm_hit` pulses.
- R8: `supply_rdata` has the supply-valid bit at bit 7 and 0 in bits 6:0. A high `low_volt` clears the bit in the next cycle. A `supply_rd` with `low_volt` low sets the bit to 1 in the next cycle. In any other case the bit holds its value, and a read returns the value from before the read.
- R9: A synchronous active-low `rst_n` clears all three flags and the supply-valid bit, which leaves `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Software RTC reset; clears the periodic and update flags |
| rtc_disable | input | 1 | RTC disabled; holds the periodic and update flags clear |
| periodic_tick | input | 1 | Pulse: transition on the selected divider tap |
| alarm_hit | input | 1 | Pulse: alarm match |
| update_done | input | 1 | Pulse: time registers updated |
| en_periodic | input | 1 | Interrupt enable for the periodic flag |
| en_alarm | input | 1 | Interrupt enable for the alarm flag |
| en_update | input | 1 | Interrupt enable for the update flag |
| flag_rd | input | 1 | Read strobe of the status byte |
| supply_rd | input | 1 | Read strobe of the supply-status byte |
| low_volt | input | 1 | Low-voltage detect of the RTC supply |
| flag_rdata | output | 8 | Status byte |
| supply_rdata | output | 8 | Supply-status byte |
| irq_out | output | 1 | Interrupt output |

## Verification
The bench first sends each event alone and changes the enables while its flag is set. This separates the storage of a flag from its gating into the interrupt. It then places a status read in the same cycle as each event, and in the same cycle as a software reset and as a disable. These cases show whether the clear, the set and the forced clear take effect in the right order. Low-voltage pulses, with supply reads before, during and after them, check the sticky valid bit and its hold on the alarm flag. A long pseudo-random phase then mixes all the inputs, and a behavioural model checks every cycle.

// File: rtl/rtc_irq_pkg.sv
// Package: field positions and sizes shared by the RTC interrupt status logic.
// Assumes an 8-bit register read path.
package rtc_irq_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 3;
    localparam int FLAG_LSB  = 4;          // flags occupy [FLAG_LSB +: NUM_FLAGS]
    localparam int SUM_BIT   = REG_W - 1;  // summary interrupt bit
    localparam int VALID_BIT = REG_W - 1;  // supply-valid bit position
    localparam int FLG_UPDATE   = 0;
    localparam int FLG_ALARM    = 1;
    localparam int FLG_PERIODIC = 2;
endpackage

// File: rtl/rtc_evt_flag.sv
// Module: one sticky event flag.
// Set by a one-cycle pulse and cleared by a register read. A force-clear
// overrides both. A set that arrives with a read is kept.
// Assumes a synchronous active-low reset.
module rtc_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_clr_i,
    input  logic hold_clr_i,
    output logic flag_o
);
    logic flag_q;

    // Flag storage: force-clear, then clear-on-read OR new event.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (hold_clr_i) flag_q <= 1'b0;
        else                 flag_q <= (flag_q & ~rd_clr_i) | set_i;
    end

    assign flag_o = flag_q;

    // R4: a read with no new event leaves the flag clear
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !set_i) |=> !flag_q);
    // R5: an event without force-clear is always captured, even during a read
    a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !hold_clr_i) |=> flag_q);
    // R6: force-clear wins over a simultaneous event
    a_r6_hold_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr_i |=> !flag_q);
endmodule

// File: rtl/rtc_supply_mon.sv
// Module: sticky supply-valid bit.
// Low voltage clears it. A read of the supply-status byte re-arms it
// unless low voltage is still present. Also gives the next-state value,
// so that other logic can act in the same edge as the change.
// Assumes a synchronous active-low reset, and that power-up leaves the
// contents untrusted (reset value 0).
module rtc_supply_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic low_volt_i,
    input  logic rd_i,
    output logic valid_o,
    output logic valid_nxt_o
);
    logic valid_q;
    logic valid_d;

    // Next state: low voltage dominates, then re-arm on read.
    always_comb begin
        if (low_volt_i) valid_d = 1'b0;
        else if (rd_i)  valid_d = 1'b1;
        else            valid_d = valid_q;
    end

    // Valid-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    assign valid_o     = valid_q;
    assign valid_nxt_o = valid_d;

    // R8: low voltage always invalidates
    a_r8_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        low_volt_i |=> !valid_q);
    // R8: a clean read re-arms
    a_r8_read_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !low_volt_i) |=> valid_q);
    // R8: otherwise sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && !low_volt_i) |=> $stable(valid_q));
endmodule

// File: rtl/rtc_irq_combine.sv
// Module: interrupt equation. The interrupt is active when any flag is
// set together with its own enable. Purely combinational.
module rtc_irq_combine
    import rtc_irq_pkg::*;
(
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic [NUM_FLAGS-1:0] en_i,
    output logic                 irq_o
);
    // OR of the enabled flags.
    always_comb irq_o = |(flags_i & en_i);
endmodule

// File: rtl/rtc_irq_status.sv
// Module: RTC interrupt status register, top level.
// Holds the periodic, alarm and update flags, the enable gating and the
// sticky supply-valid bit, and drives the interrupt line.
// Assumes that the read strobes last one cycle per access, and that the
// read data is sampled in the same cycle as the strobe.
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             rtc_disable,
    input  logic             periodic_tick,
    input  logic             alarm_hit,
    input  logic             update_done,
    input  logic             en_periodic,
    input  logic             en_alarm,
    input  logic             en_update,
    input  logic             flag_rd,
    input  logic             supply_rd,
    input  logic             low_volt,
    output logic [REG_W-1:0] flag_rdata,
    output logic [REG_W-1:0] supply_rdata,
    output logic             irq_out
);
    logic [NUM_FLAGS-1:0] evt;
    logic [NUM_FLAGS-1:0] en;
    logic [NUM_FLAGS-1:0] flags;
    logic                 valid;
    logic                 valid_nxt;
    logic                 irq;

    // Gather the event pulses and the enables into flag-indexed vectors.
    always_comb begin
        evt = '0;
        en  = '0;
        evt[FLG_UPDATE]   = update_done;
        evt[FLG_ALARM]    = alarm_hit;
        evt[FLG_PERIODIC] = periodic_tick;
        en[FLG_UPDATE]    = en_update;
        en[FLG_ALARM]     = en_alarm;
        en[FLG_PERIODIC]  = en_periodic;
    end

    rtc_supply_mon u_supply (
        .clk         (clk),
        .rst_n       (rst_n),
        .low_volt_i  (low_volt),
        .rd_i        (supply_rd),
        .valid_o     (valid),
        .valid_nxt_o (valid_nxt)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic clr;
        if (i == FLG_ALARM) begin : g_alarm
            // Alarm is held clear while the supply-valid bit is (or becomes) 0.
            assign clr = ~valid_nxt;
        end else begin : g_timebase
            // Time-base flags follow the software reset and the RTC disable.
            assign clr = soft_rst | rtc_disable;
        end
        rtc_evt_flag u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (evt[i]),
            .rd_clr_i   (flag_rd),
            .hold_clr_i (clr),
            .flag_o     (flags[i])
        );
    end

    rtc_irq_combine u_comb (
        .flags_i (flags),
        .en_i    (en),
        .irq_o   (irq)
    );

    // Assemble the two read bytes; unused bits read 0.
    always_comb begin
        flag_rdata                           = '0;
        flag_rdata[SUM_BIT]                  = irq;
        flag_rdata[FLAG_LSB +: NUM_FLAGS]    = flags;
        supply_rdata                         = '0;
        supply_rdata[VALID_BIT]              = valid;
    end

    assign irq_out = irq;

    // R7: whenever the supply bit reads 0, the alarm flag reads 0
    a_r7_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_rdata[VALID_BIT] |-> !flag_rdata[FLAG_LSB + FLG_ALARM]);
    // R4: a read with no events, no enable change drops the interrupt
    a_r4_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !periodic_tick && !alarm_hit && !update_done) |=> !irq_out);
    // R9: first cycle after reset release has no interrupt
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (flags == '0) && !valid);
endmodule

// File: tb/rtc_irq_status_test.sv
// Bench: behavioural reference model, compared with the design on every clock.
module rtc_irq_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst_n, soft_rst, rtc_disable, periodic_tick, alarm_hit, update_done;
    logic en_periodic, en_alarm, en_update, flag_rd, supply_rd, low_volt;
    logic [7:0] flag_rdata, supply_rdata;
    logic irq_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    bit done = 1'b0;

    // model state
    bit m_p = 0, m_a = 0, m_u = 0, m_v = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_status uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rtc_disable(rtc_disable),
        .periodic_tick(periodic_tick), .alarm_hit(alarm_hit), .update_done(update_done),
        .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
        .flag_rd(flag_rd), .supply_rd(supply_rd), .low_volt(low_volt),
        .flag_rdata(flag_rdata), .supply_rdata(supply_rdata), .irq_out(irq_out)
    );

    // Reference model: applies the requirement rules at each rising edge.
    always @(posedge clk) begin
        bit nv;
        if (!rst_n) begin
            m_p = 0; m_a = 0; m_u = 0; m_v = 0;
        end else begin
            nv = low_volt ? 1'b0 : (supply_rd ? 1'b1 : m_v);
            if (soft_rst || rtc_disable) begin
                m_p = 0; m_u = 0;
            end else begin
                m_p = (m_p && !flag_rd) || periodic_tick;
                m_u = (m_u && !flag_rd) || update_done;
            end
            m_a = nv ? ((m_a && !flag_rd) || alarm_hit) : 1'b0;
            m_v = nv;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model, then advance one clock.
    task automatic tick();
        bit irq_e;
        #1;
        irq_e = (en_update && m_u) || (en_alarm && m_a) || (en_periodic && m_p);
        check(flag_rdata[3:0] == 4'h0, "R1", flag_rdata[3:0], 0);
        check(flag_rdata[6:4] == {m_p, m_a, m_u}, cur_req, flag_rdata[6:4], {m_p, m_a, m_u});
        check(flag_rdata[7] == irq_e, "R3", flag_rdata[7], irq_e);
        check(irq_out == irq_e, "R3", irq_out, irq_e);
        check(supply_rdata == {m_v, 7'b0}, "R8", supply_rdata, {m_v, 7'b0});
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        soft_rst = 0; rtc_disable = 0; periodic_tick = 0; alarm_hit = 0;
        update_done = 0; flag_rd = 0; supply_rd = 0; low_volt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle();
        en_periodic = 0; en_alarm = 0; en_update = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        #1;
        check(flag_rdata == 8'h00, "R9", flag_rdata, 0);
        check(supply_rdata == 8'h00, "R9", supply_rdata, 0);
        check(irq_out == 1'b0, "R9", irq_out, 0);
        rst_n = 1;
        cur_req = "R9"; tick();

        // R8: arm the supply bit
        cur_req = "R8"; supply_rd = 1; tick(); supply_rd = 0; tick();
        check(supply_rdata[7] == 1'b1, "R8", supply_rdata[7], 1);

        // R2: each event alone, enables off
        cur_req = "R2";
        periodic_tick = 1; tick(); periodic_tick = 0; tick();
        alarm_hit = 1; tick(); alarm_hit = 0; tick();
        update_done = 1; tick(); update_done = 0; tick();
        check(flag_rdata[6:4] == 3'b111 && !irq_out, "R2", flag_rdata, 8'h70);

        // R3: walk the enables with flags set
        cur_req = "R3";
        en_alarm = 1; tick(); en_alarm = 0; en_update = 1; tick();
        en_update = 0; en_periodic = 1; tick();
        #1; check(irq_out == 1'b1 && flag_rdata == 8'hF0, "R3", flag_rdata, 8'hF0);
        en_periodic = 0; tick();

        // R4: read returns pre-clear value, then clears
        cur_req = "R4"; en_alarm = 1; en_update = 1; en_periodic = 1;
        flag_rd = 1;
        #1; check(flag_rdata == 8'hF0, "R4", flag_rdata, 8'hF0);
        tick(); flag_rd = 0;
        #1; check(flag_rdata == 8'h00 && !irq_out, "R4", flag_rdata, 0);
        tick();

        // R5: event during a read is kept
        cur_req = "R5"; alarm_hit = 1; tick(); alarm_hit = 0;
        flag_rd = 1; update_done = 1; tick(); flag_rd = 0; update_done = 0;
        #1; check(flag_rdata == 8'h90, "R5", flag_rdata, 8'h90);
        tick();

        // R6: soft reset and disable beat events, alarm untouched
        cur_req = "R6"; alarm_hit = 1; periodic_tick = 1; tick();
        alarm_hit = 0; periodic_tick = 0;
        soft_rst = 1; periodic_tick = 1; update_done = 1; tick();
        soft_rst = 0; periodic_tick = 0; update_done = 0;
        #1; check(flag_rdata[6:4] == 3'b010, "R6", flag_rdata[6:4], 3'b010);
        rtc_disable = 1;
        for (int i = 0; i < 3; i++) begin
            periodic_tick = 1; update_done = 1; tick();
        end
        periodic_tick = 0; update_done = 0;
        #1; check(flag_rdata[6:4] == 3'b010, "R6", flag_rdata[6:4], 3'b010);
        rtc_disable = 0; flag_rd = 1; tick(); flag_rd = 0; tick();

        // R7/R8: low voltage clears valid, holds alarm clear
        cur_req = "R7"; alarm_hit = 1; tick(); alarm_hit = 0;
        low_volt = 1; supply_rd = 1; alarm_hit = 1; tick();
        #1; check(supply_rdata[7] == 1'b0 && flag_rdata[5] == 1'b0, "R7", flag_rdata, 0);
        tick(); low_volt = 0; supply_rd = 0;
        for (int i = 0; i < 3; i++) tick();
        #1; check(flag_rdata[5] == 1'b0, "R7", flag_rdata[5], 0);
        alarm_hit = 0; cur_req = "R8"; supply_rd = 1;
        #1; check(supply_rdata[7] == 1'b0, "R8", supply_rdata[7], 0);
        tick(); supply_rd = 0;
        #1; check(supply_rdata[7] == 1'b1, "R8", supply_rdata[7], 1);
        tick();

        // mixed pseudo-random phase
        cur_req = "R2";
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            r = $urandom;
            periodic_tick = (r[3:0] == 0); alarm_hit = (r[7:4] == 1);
            update_done = (r[11:8] == 2); flag_rd = (r[14:12] == 3);
            supply_rd = (r[18:15] == 4); low_volt = (r[23:19] == 5);
            soft_rst = (r[27:24] == 6); rtc_disable = (r[31:28] == 7);
            en_periodic = r[1]; en_alarm = r[5]; en_update = r[9];
            tick();
        end
        idle();
        // R9: reset mid-run clears everything
        rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
        #1; check(flag_rdata[6:0] == 0 && supply_rdata == 0 && !irq_out, "R9", flag_rdata, 0);
        cur_req = "R9"; tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule